// File: doc/BRIEF.md
# Masked Vector Lane Writeback

This block builds the packed result of a 32-bit-per-lane vector operation. Before the arithmetic, it chooses the operand for each lane: the lane's own source element, or element 0 repeated across all lanes when a scalar from memory is broadcast. After the arithmetic, it takes the per-lane results, the old destination value, a per-lane write mask and a masking mode, and forms the new 512-bit destination. Lanes outside the active vector length are cleared.

A vector-length select picks 4, 8 or 16 active lanes. When masking is disabled, every active lane takes its new result. When masking is enabled, a lane whose mask bit is clear either keeps its old value (merge) or becomes zero (zero mode). The destination is registered, and a valid pulse marks each update.

Top module: `vec_mask_writeback`

## Requirements
- R1: `vlen_sel` selects the active lane count: 2'b00 gives 4 lanes (bits 127:0), 2'b01 gives 8 lanes (bits 255:0), 2'b10 gives 16 lanes (bits 511:0). The code 2'b11 behaves as 16 lanes. Lane j occupies bits 32*j+31 : 32*j.
- R2: An active lane j takes `lane_res` element j when `mask_en` is 0, or when `mask_en` is 1 and `mask[j]` is 1.
- R3: With `mask_en` 1 and `zero_mode` 0, an active lane whose mask bit is 0 keeps its `old_dst` element.
- R4: With `mask_en` 1 and `zero_mode` 1, an active lane whose mask bit is 0 is written with 32'h0.
- R5: When `bcast` and `src_is_mem` are both 1, `lane_opnd` carries `src_vec[31:0]` in every active lane. Otherwise active lane j carries `src_vec` element j.
- R6: When `src_is_mem` is 0, `bcast` has no effect on `lane_opnd` or on `dst`.
- R7: Every `dst` bit at or above 32 times the active lane count is 0 after an update, whatever the mask, mode and inputs. `lane_opnd` lanes beyond the active count are also 0.
- R8: Mask bits at or above the active lane count have no effect on `dst`.
- R9: `dst` and `out_valid` are registered. `out_valid` is 1 exactly in the cycle after a cycle with `in_valid` 1. `dst` holds its value when `in_valid` is 0.
- R10: After reset, `out_valid` is 0 and `dst` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Inputs are valid and must be written back |
| vlen_sel | input | 2 | Vector length code |
| mask_en | input | 1 | 1 applies the write mask |
| mask | input | 16 | Per-lane write mask |
| zero_mode | input | 1 | 1 zeroes unmasked lanes, 0 merges them |
| bcast | input | 1 | Broadcast request |
| src_is_mem | input | 1 | Source operand comes from memory |
| src_vec | input | 512 | Source elements |
| lane_opnd | output | 512 | Operand chosen for each lane |
| old_dst | input | 512 | Previous destination value |
| lane_res | input | 512 | Per-lane operation results |
| out_valid | output | 1 | New destination is valid |
| dst | output | 512 | Registered destination |

## Verification
Assertions check on every cycle:
- the valid timing and the hold behaviour of `dst`;
- the clearing above a 4-lane length;
- the broadcast operand in lane 1;
- zeroing of a masked-off lane 0.

Only the bench scenarios can show the rest: the full lane-by-lane result under mixed masks, modes and lengths; that mask bits above the active length are ignored; and that the broadcast flag has no effect with a register source. The bench compares these results against its own behavioural model.

// File: rtl/vec_mask_writeback.sv
module vec_mask_writeback #(
  parameter int LANE_W    = 32,
  parameter int MAX_LANES = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic [1:0]                  vlen_sel,
  input  logic                        mask_en,
  input  logic [MAX_LANES-1:0]        mask,
  input  logic                        zero_mode,
  input  logic                        bcast,
  input  logic                        src_is_mem,
  input  logic [MAX_LANES*LANE_W-1:0] src_vec,
  output logic [MAX_LANES*LANE_W-1:0] lane_opnd,
  input  logic [MAX_LANES*LANE_W-1:0] old_dst,
  input  logic [MAX_LANES*LANE_W-1:0] lane_res,
  output logic                        out_valid,
  output logic [MAX_LANES*LANE_W-1:0] dst
);
  localparam int VW = MAX_LANES * LANE_W;
  localparam int CW = $clog2(MAX_LANES + 1);

  logic [CW-1:0]        n_act;
  logic [MAX_LANES-1:0] lane_act;
  logic                 use_bcast;
  logic [VW-1:0]        nxt;

  always_comb begin
    case (vlen_sel)
      2'b00:   n_act = CW'(4);
      2'b01:   n_act = CW'(8);
      default: n_act = CW'(16);
    endcase
  end

  assign use_bcast = bcast & src_is_mem;

  for (genvar j = 0; j < MAX_LANES; j++) begin : g_lane
    logic wr;
    assign lane_act[j] = (CW'(j) < n_act);
    assign wr = lane_act[j] & (~mask_en | mask[j]);
    assign lane_opnd[j*LANE_W +: LANE_W] = !lane_act[j] ? '0 :
           use_bcast ? src_vec[LANE_W-1:0] : src_vec[j*LANE_W +: LANE_W];
    assign nxt[j*LANE_W +: LANE_W] = !lane_act[j] ? '0 :
           wr ? lane_res[j*LANE_W +: LANE_W] :
           zero_mode ? '0 : old_dst[j*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      dst       <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) dst <= nxt;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R9
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R9
  AST_DST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(dst)); // R9
  AST_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && vlen_sel == 2'b00) |=> dst[VW-1:4*LANE_W] == '0); // R7
  AST_BCAST_LANE1: assert property (@(posedge clk) disable iff (!rst_n)
    (bcast && src_is_mem) |-> lane_opnd[2*LANE_W-1:LANE_W] == src_vec[LANE_W-1:0]); // R5
  AST_ZERO_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mask_en && zero_mode && !mask[0]) |=> dst[LANE_W-1:0] == '0); // R4
endmodule

// File: tb/tb_vec_mask_writeback.sv
module tb_vec_mask_writeback;
  localparam int CLK_PERIOD = 10;
  localparam int VW = 512;

  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [1:0] vlen_sel = 0;
  logic mask_en = 0, zero_mode = 0, bcast = 0, src_is_mem = 0;
  logic [15:0] mask = 0;
  logic [VW-1:0] src_vec = '0, old_dst = '0, lane_res = '0;
  logic [VW-1:0] lane_opnd, dst;
  logic out_valid;
  int checks = 0, failures = 0;

  vec_mask_writeback dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .vlen_sel(vlen_sel), .mask_en(mask_en), .mask(mask), .zero_mode(zero_mode),
    .bcast(bcast), .src_is_mem(src_is_mem), .src_vec(src_vec),
    .lane_opnd(lane_opnd), .old_dst(old_dst), .lane_res(lane_res),
    .out_valid(out_valid), .dst(dst));

  always #(CLK_PERIOD/2) clk = ~clk;

  // {vlen_sel, mask_en, zero_mode, bcast, src_is_mem, mask}
  localparam int NV = 10;
  localparam logic [21:0] VEC [NV] = '{
    {2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 16'hFFFF},
    {2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 16'h00A5},
    {2'b10, 1'b1, 1'b1, 1'b0, 1'b0, 16'h5A3C},
    {2'b00, 1'b1, 1'b1, 1'b1, 1'b1, 16'hFFF5},
    {2'b01, 1'b1, 1'b0, 1'b1, 1'b0, 16'hFF0F},
    {2'b11, 1'b1, 1'b0, 1'b1, 1'b1, 16'h8001},
    {2'b10, 1'b0, 1'b1, 1'b1, 1'b1, 16'h0000},
    {2'b01, 1'b1, 1'b1, 1'b0, 1'b1, 16'hFF00},
    {2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000},
    {2'b10, 1'b1, 1'b1, 1'b1, 1'b0, 16'hFFFF}};

  function automatic int lanes(input logic [1:0] v);
    return v == 2'b00 ? 4 : v == 2'b01 ? 8 : 16;
  endfunction

  function automatic logic [VW-1:0] model_dst();
    logic [VW-1:0] r = '0;
    for (int j = 0; j < lanes(vlen_sel); j++)
      if (!mask_en || mask[j]) r[j*32 +: 32] = lane_res[j*32 +: 32];
      else if (!zero_mode)     r[j*32 +: 32] = old_dst[j*32 +: 32];
    return r;
  endfunction

  function automatic logic [VW-1:0] model_opnd();
    logic [VW-1:0] r = '0;
    for (int j = 0; j < lanes(vlen_sel); j++)
      r[j*32 +: 32] = (bcast && src_is_mem) ? src_vec[31:0] : src_vec[j*32 +: 32];
    return r;
  endfunction

  task automatic check(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic fill_data(input int seed);
    for (int j = 0; j < 16; j++) begin
      src_vec[j*32 +: 32]  = 32'hC000_0000 | (seed << 8) | j;
      old_dst[j*32 +: 32]  = 32'h5000_0000 | (seed << 8) | j;
      lane_res[j*32 +: 32] = 32'hA000_0000 | (seed << 8) | j;
    end
  endtask

  task automatic run_case(input string req);
    logic [VW-1:0] e;
    @(negedge clk);
    check({req, " opnd R5"}, lane_opnd, model_opnd());
    e = model_dst();
    in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    check({req, " valid R9"}, {511'b0, out_valid}, {511'b0, 1'b1});
    check({req, " dst"}, dst, e);
    @(negedge clk);
    check({req, " hold R9"}, dst, e);
    check({req, " valid drop R9"}, {511'b0, out_valid}, '0);
  endtask

  initial begin
    logic [VW-1:0] ref_d;
    #(CLK_PERIOD*2.5);
    check("R10 reset valid", {511'b0, out_valid}, '0);
    check("R10 reset dst", dst, '0);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      fill_data(i);
      {vlen_sel, mask_en, zero_mode, bcast, src_is_mem, mask} = VEC[i];
      run_case("R1 R2 R3 R4 R7 table");
    end

    // R8: upper mask bits flipped give identical result at 4 lanes
    fill_data(20);
    {vlen_sel, mask_en, zero_mode, bcast, src_is_mem} = {2'b00, 1'b1, 1'b0, 1'b0, 1'b0};
    mask = 16'h0005; run_case("R8 base");
    ref_d = dst;
    mask = 16'hFFF5; run_case("R8 upper set");
    check("R8 upper mask ignored", dst, ref_d);

    // R6: bcast with register source has no effect
    fill_data(21);
    {vlen_sel, mask_en, zero_mode, src_is_mem, mask} = {2'b10, 1'b1, 1'b0, 1'b0, 16'h0F0F};
    bcast = 0; run_case("R6 base");
    ref_d = lane_opnd;
    bcast = 1; #1;
    check("R6 opnd unchanged", lane_opnd, ref_d);
    run_case("R6 bcast reg");

    // R7: 8 lanes, masked off all, merge: upper half must stay zero
    fill_data(22);
    {vlen_sel, mask_en, zero_mode, bcast, src_is_mem, mask} = {2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000};
    run_case("R7 upper");
    check("R7 upper zero", {256'b0, dst[511:256]}, '0);

    // random mix
    for (int k = 0; k < 40; k++) begin
      for (int j = 0; j < 16; j++) begin
        src_vec[j*32 +: 32] = $urandom; old_dst[j*32 +: 32] = $urandom;
        lane_res[j*32 +: 32] = $urandom;
      end
      vlen_sel = 2'($urandom); mask = 16'($urandom); mask_en = 1'($urandom);
      zero_mode = 1'($urandom); bcast = 1'($urandom); src_is_mem = 1'($urandom);
      run_case("R2 R3 R4 R5 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*20000);
    failures++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule